// File: doc/BRIEF.md
# DRAM Controller Configuration Register Block

This block holds the control and status registers of a simple DDR controller. It offers three register windows: a common window, a controller window and a PHY window. A single word-addressed bus port reaches them. Each access names a window code and a word offset, and carries a read strobe, a write strobe and 32-bit write data. Read data comes back one cycle after the read strobe. All accesses are full 32-bit words.

Some writes have side effects beyond the register they target. A write to the common control word with its dual-rank bit clear decodes a memory geometry. The block then drives row, bank and column address widths to a downstream address mapper, together with a one-cycle valid pulse. Any write to the controller's PHY-init word marks initialisation as done and the controller as active. A separate probe input reports reads of a missing second rank. When timeout reporting is enabled, such a read raises a read-timeout flag that stays set. Command generation, DRAM timing and the PHY itself belong to other blocks.

Top module: `dram_cfg_regs`

## Requirements
- R1: After reset every word in all windows reads zero, the geometry outputs hold row 1, bank 2 and column 3, and the geometry-valid output is low.
- R2: A read strobe in one cycle returns the addressed word on the read data output in the next cycle. In a cycle that follows no read strobe, the read data output is zero.
- R3: A write to common window (code 0) word 0 with bit 0 clear sets the row width to bits [7:4] + 1, the bank width to bit [2] + 2 and the column width to bits [11:8] + 3. The new widths appear in the cycle after the write.
- R4: The geometry-valid output is high for exactly the one cycle in which new widths first appear. In every other cycle the widths hold their values.
- R5: A write to common word 0 with bit 0 set stores the value but leaves the widths unchanged and gives no valid pulse.
- R6: Any write to controller window (code 1) word 0 stores the written value. It also sets bit 0 of controller word 4 (PHY status, init done) and bit 0 of controller word 6 (controller status, active).
- R7: A probe pulse while bit 25 of controller word 64 (PHY configuration) is set sets bit 13 of controller word 4 (read timeout). A probe pulse while that bit is clear changes nothing.
- R8: Flags set as side effects stay set until software writes the word. If a software write to that word and a flag set happen in the same cycle, the flag is set on top of the written value.
- R9: A word offset at or beyond a window's word count (common 4, controller 128, PHY 64) reads zero, and a write to it changes no register.
- R10: Window code 3 selects nothing: reads return zero and writes change no register.
- R11: Words without side effects, in the PHY window and elsewhere, read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_i | input | 2 | Window code: 0 common, 1 controller, 2 PHY, 3 none |
| off_i | input | 10 | Word offset within the window |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| probe_rd_i | input | 1 | One-cycle pulse marking a read of the absent second rank |
| row_bits_o | output | 5 | Decoded row address width |
| bank_bits_o | output | 2 | Decoded bank address width |
| col_bits_o | output | 5 | Decoded column address width |
| geom_vld_o | output | 1 | One-cycle pulse when new widths appear |

## Verification
The bench targets three kinds of corner case.

The first is the dual-rank bit on common word 0. A design that ignored it would change the widths and pulse valid when it should do neither.

The second is out-of-range offsets such as 72 plus 128, and window code 3. A design that cut off the upper offset bits would alias these accesses onto real words and corrupt them. The bench reads the possible alias targets back after each such write.

The third is the timeout flag. The bench applies a probe pulse with the enable bit clear, where a design that did not gate the probe would set bit 13. It also applies a probe pulse in the same cycle as a software write to the status word, where a design that let the write win would lose the flag.

// File: rtl/dramcfg_pkg.sv
package dramcfg_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    WIN_COM  = 2'd0,
    WIN_CTL  = 2'd1,
    WIN_PHY  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  // controller window word indices
  localparam int IDX_PHY_INIT = 0;
  localparam int IDX_PHY_STAT = 4;
  localparam int IDX_CTL_STAT = 6;
  localparam int IDX_PHY_CFG  = 64;

  localparam int BIT_INIT_DONE = 0;
  localparam int BIT_ACTIVE    = 0;
  localparam int BIT_RD_TMO    = 13;
  localparam int BIT_TMO_EN    = 25;

  // common control word fields
  localparam int BIT_DUAL    = 0;
  localparam int BIT_BANK    = 2;
  localparam int ROW_LSB     = 4;
  localparam int COL_LSB     = 8;
  localparam int FLD_W       = 4;
  localparam int ROW_OFS     = 1;
  localparam int BANK_OFS    = 2;
  localparam int COL_OFS     = 3;
endpackage

// File: rtl/dramcfg_regfile.sv
module dramcfg_regfile #(
  parameter int DEPTH    = 4,
  parameter int OFF_W    = 10,
  parameter int PEEK_IDX = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [OFF_W-1:0]            addr_i,
  input  logic [31:0]                 wdata_i,
  input  logic [DEPTH-1:0][31:0]      set_i,
  output logic [31:0]                 rdata_o,
  output logic [31:0]                 peek_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][31:0] mem_q;
  logic                   in_range;

  assign in_range = int'(addr_i) < DEPTH;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we_i && in_range && (addr_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mem_q[g] <= '0;
      else if (hit || |set_i[g])    mem_q[g] <= (hit ? wdata_i : mem_q[g]) | set_i[g];
    end

    // R8: a requested flag is present after the edge, even under a write
    a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_i[g]) |=> ((mem_q[g] & $past(set_i[g])) == $past(set_i[g])));
  end

  assign rdata_o = in_range ? mem_q[addr_i[IDX_W-1:0]] : '0;
  assign peek_o  = mem_q[PEEK_IDX];
endmodule

// File: rtl/dramcfg_geom.sv
module dramcfg_geom
  import dramcfg_pkg::*;
#(
  parameter int ROW_W  = 5,
  parameter int BANK_W = 2,
  parameter int COL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              dual_i,
  input  logic              bank_sel_i,
  input  logic [FLD_W-1:0]  row_fld_i,
  input  logic [FLD_W-1:0]  col_fld_i,
  output logic [ROW_W-1:0]  row_bits_o,
  output logic [BANK_W-1:0] bank_bits_o,
  output logic [COL_W-1:0]  col_bits_o,
  output logic              vld_o
);
  logic upd;
  assign upd = we_i && !dual_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_bits_o  <= ROW_W'(ROW_OFS);
      bank_bits_o <= BANK_W'(BANK_OFS);
      col_bits_o  <= COL_W'(COL_OFS);
      vld_o       <= 1'b0;
    end else begin
      vld_o <= upd;
      if (upd) begin
        row_bits_o  <= ROW_W'(row_fld_i) + ROW_W'(ROW_OFS);
        bank_bits_o <= BANK_W'(bank_sel_i) + BANK_W'(BANK_OFS);
        col_bits_o  <= COL_W'(col_fld_i) + COL_W'(COL_OFS);
      end
    end
  end

  a_r4_hold_widths: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable({row_bits_o, bank_bits_o, col_bits_o}));

  a_r5_dual_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dual_i) |=> !vld_o);

  a_r3_bank_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_bits_o >= BANK_W'(BANK_OFS));
endmodule

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs
  import dramcfg_pkg::*;
#(
  parameter int OFF_W     = 10,
  parameter int COM_WORDS = 4,
  parameter int CTL_WORDS = 128,
  parameter int PHY_WORDS = 64,
  parameter int ROW_W     = 5,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        win_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              probe_rd_i,
  output logic [ROW_W-1:0]  row_bits_o,
  output logic [BANK_W-1:0] bank_bits_o,
  output logic [COL_W-1:0]  col_bits_o,
  output logic              geom_vld_o
);
  logic com_we, ctl_we, phy_we, pir_wr, tmo_en;
  logic [31:0] com_rd, ctl_rd, phy_rd, rdata_d;
  logic [31:0] ctl_peek, unused_com_peek, unused_phy_peek;
  logic [CTL_WORDS-1:0][31:0] ctl_set;
  logic unused_ctl;

  assign com_we = wr_i && (win_i == WIN_COM);
  assign ctl_we = wr_i && (win_i == WIN_CTL);
  assign phy_we = wr_i && (win_i == WIN_PHY);
  assign pir_wr = ctl_we && (off_i == OFF_W'(IDX_PHY_INIT));
  assign tmo_en = ctl_peek[BIT_TMO_EN];
  assign unused_ctl = ^{ctl_peek[31:BIT_TMO_EN+1], ctl_peek[BIT_TMO_EN-1:0]};

  always_comb begin
    ctl_set = '0;
    if (pir_wr) begin
      ctl_set[IDX_PHY_STAT][BIT_INIT_DONE] = 1'b1;
      ctl_set[IDX_CTL_STAT][BIT_ACTIVE]    = 1'b1;
    end
    if (probe_rd_i && tmo_en) ctl_set[IDX_PHY_STAT][BIT_RD_TMO] = 1'b1;
  end

  dramcfg_regfile #(.DEPTH(COM_WORDS), .OFF_W(OFF_W), .PEEK_IDX(0)) i_com (
    .clk_i, .rst_ni, .we_i(com_we), .addr_i(off_i), .wdata_i,
    .set_i('0), .rdata_o(com_rd), .peek_o(unused_com_peek));

  dramcfg_regfile #(.DEPTH(CTL_WORDS), .OFF_W(OFF_W), .PEEK_IDX(IDX_PHY_CFG)) i_ctl (
    .clk_i, .rst_ni, .we_i(ctl_we), .addr_i(off_i), .wdata_i,
    .set_i(ctl_set), .rdata_o(ctl_rd), .peek_o(ctl_peek));

  dramcfg_regfile #(.DEPTH(PHY_WORDS), .OFF_W(OFF_W), .PEEK_IDX(0)) i_phy (
    .clk_i, .rst_ni, .we_i(phy_we), .addr_i(off_i), .wdata_i,
    .set_i('0), .rdata_o(phy_rd), .peek_o(unused_phy_peek));

  dramcfg_geom #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) i_geom (
    .clk_i, .rst_ni,
    .we_i       (com_we && (off_i == '0)),
    .dual_i     (wdata_i[BIT_DUAL]),
    .bank_sel_i (wdata_i[BIT_BANK]),
    .row_fld_i  (wdata_i[ROW_LSB +: FLD_W]),
    .col_fld_i  (wdata_i[COL_LSB +: FLD_W]),
    .row_bits_o, .bank_bits_o, .col_bits_o,
    .vld_o      (geom_vld_o));

  always_comb begin
    unique case (win_i)
      WIN_COM: rdata_d = com_rd;
      WIN_CTL: rdata_d = ctl_rd;
      WIN_PHY: rdata_d = phy_rd;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_i ? rdata_d : '0;
  end

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

  a_r10_none_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (win_i == WIN_NONE)) |=> (rdata_o == '0));

  a_r9_ctl_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (win_i == WIN_CTL) && (int'(off_i) >= CTL_WORDS)) |=> (rdata_o == '0));
endmodule

// File: tb/test_dram_cfg_regs.sv
module test_dram_cfg_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] win = '0;
  logic [9:0] off = '0;
  logic wr = 1'b0, rd = 1'b0, probe = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0] row_b, col_b;
  logic [1:0] bank_b;
  logic vld;

  int vec = 0, err = 0;
  bit done = 0;

  logic [31:0] com_m [4];
  logic [31:0] ctl_m [128];
  logic [31:0] phy_m [64];
  logic [4:0] e_row = 5'd1, e_col = 5'd3;
  logic [1:0] e_bank = 2'd2;

  always #2.5 clk = ~clk;

  dram_cfg_regs i_dram_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .off_i(off), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .probe_rd_i(probe),
    .row_bits_o(row_b), .bank_bits_o(bank_b), .col_bits_o(col_b), .geom_vld_o(vld));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] w, logic [9:0] o);
    case (w)
      2'd0: return (o < 4)   ? com_m[o] : 32'h0;
      2'd1: return (o < 128) ? ctl_m[o] : 32'h0;
      2'd2: return (o < 64)  ? phy_m[o] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [1:0] w, logic [9:0] o, logic [31:0] d, bit prb);
    case (w)
      2'd0: if (o < 4) com_m[o] = d;
      2'd1: if (o < 128) begin
        ctl_m[o] = d;
        if (o == 0) begin ctl_m[4][0] = 1'b1; ctl_m[6][0] = 1'b1; end
      end
      2'd2: if (o < 64) phy_m[o] = d;
      default: ;
    endcase
    if (prb && ctl_m[64][25]) ctl_m[4][13] = 1'b1;
  endtask

  task automatic do_wr(logic [1:0] w, logic [9:0] o, logic [31:0] d, bit prb = 0);
    bit geo;
    logic [4:0] r0, c0;
    logic [1:0] b0;
    geo = (w == 2'd0) && (o == 0);
    r0 = e_row; b0 = e_bank; c0 = e_col;
    @(negedge clk);
    win = w; off = o; wdata = d; wr = 1'b1; probe = prb;
    @(negedge clk);
    wr = 1'b0; probe = 1'b0;
    model_wr(w, o, d, prb);
    if (geo && !d[0]) begin
      e_row = {1'b0, d[7:4]} + 5'd1;
      e_bank = {1'b0, d[2]} + 2'd2;
      e_col = {1'b0, d[11:8]} + 5'd3;
      chk("R3 row", 32'(row_b), 32'(e_row));
      chk("R3 bank", 32'(bank_b), 32'(e_bank));
      chk("R3 col", 32'(col_b), 32'(e_col));
      chk("R4 valid pulse", 32'(vld), 32'd1);
      @(negedge clk);
      chk("R4 valid one cycle", 32'(vld), 32'd0);
      chk("R4 row held", 32'(row_b), 32'(e_row));
    end else if (geo) begin
      chk("R5 no pulse", 32'(vld), 32'd0);
      chk("R5 widths kept", {12'h0, row_b, bank_b, col_b, 8'h0}, {12'h0, r0, b0, c0, 8'h0});
    end
  endtask

  task automatic do_rd(logic [1:0] w, logic [9:0] o, string req);
    @(negedge clk);
    win = w; off = o; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, exp_rd(w, o));
  endtask

  task automatic do_probe();
    @(negedge clk);
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
    if (ctl_m[64][25]) ctl_m[4][13] = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      vec++; err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1a2b);
    foreach (com_m[i]) com_m[i] = '0;
    foreach (ctl_m[i]) ctl_m[i] = '0;
    foreach (phy_m[i]) phy_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 row", 32'(row_b), 32'd1);
    chk("R1 bank", 32'(bank_b), 32'd2);
    chk("R1 col", 32'(col_b), 32'd3);
    chk("R1 valid", 32'(vld), 32'd0);
    do_rd(2'd0, 10'd0, "R1 com0");
    do_rd(2'd1, 10'd4, "R1 ctl4");
    do_rd(2'd2, 10'd63, "R1 phy63");
    // R2 idle zero after a read of nonzero data
    do_wr(2'd2, 10'd5, 32'hdead_beef);
    do_rd(2'd2, 10'd5, "R11 phy readback");
    @(negedge clk);
    chk("R2 idle zero", rdata, 32'h0);
    // R3/R4/R5 geometry
    do_wr(2'd0, 10'd0, 32'h0000_0d34);
    do_wr(2'd0, 10'd0, 32'h0000_0ff1);
    do_rd(2'd0, 10'd0, "R5 dual value stored");
    do_wr(2'd0, 10'd0, 32'h0000_0000);
    do_wr(2'd0, 10'd0, 32'h0000_0ff4);
    // R6 init side effects
    do_wr(2'd1, 10'd0, 32'h1234_5678);
    do_rd(2'd1, 10'd0, "R6 pir stored");
    do_rd(2'd1, 10'd4, "R6 init done");
    do_rd(2'd1, 10'd6, "R6 active");
    // R7 probe gated off
    do_probe();
    do_rd(2'd1, 10'd4, "R7 probe disabled");
    do_wr(2'd1, 10'd64, 32'h0200_0000);
    do_probe();
    do_rd(2'd1, 10'd4, "R7 timeout set");
    // R8 sticky, software clear, write+set same cycle
    do_wr(2'd1, 10'd5, 32'h0);
    do_rd(2'd1, 10'd4, "R8 sticky");
    do_wr(2'd1, 10'd4, 32'h0);
    do_rd(2'd1, 10'd4, "R8 sw clear");
    do_wr(2'd1, 10'd4, 32'h0000_0010, 1);
    do_rd(2'd1, 10'd4, "R8 set wins");
    // R9 out of range, no alias
    do_wr(2'd1, 10'd72, 32'haaaa_5555);
    do_wr(2'd1, 10'd200, 32'h1111_2222);
    do_rd(2'd1, 10'd200, "R9 ctl oor read");
    do_rd(2'd1, 10'd72, "R9 no alias ctl");
    do_wr(2'd0, 10'd4, 32'h0000_0ff0);
    do_rd(2'd0, 10'd0, "R9 no alias com");
    do_wr(2'd2, 10'd69, 32'h7777_7777);
    do_rd(2'd2, 10'd5, "R9 no alias phy");
    // R10 none window
    do_wr(2'd3, 10'd0, 32'hffff_ffff);
    do_rd(2'd3, 10'd0, "R10 none read");
    do_rd(2'd0, 10'd0, "R10 com untouched");
    do_rd(2'd1, 10'd0, "R10 ctl untouched");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] w;
      logic [9:0] o;
      logic [31:0] d;
      int unsigned k;
      w = 2'($urandom % 4);
      k = $urandom % 8;
      if (k < 3) begin
        case ($urandom % 4)
          0: o = 10'd0; 1: o = 10'd4; 2: o = 10'd6; default: o = 10'd64;
        endcase
      end else if (k < 6) o = 10'($urandom % 130);
      else o = 10'($urandom % 1024);
      d = $urandom;
      case ($urandom % 4)
        0: do_wr(w, o, d);
        1: do_probe();
        default: do_rd(w, o, "R11 random readback");
      endcase
    end
    for (int o = 0; o < 128; o++) do_rd(2'd1, 10'(o), "R11 ctl sweep");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end
endmodule